// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block watches the input pins of a small I/O port and turns selected pin activity into interrupt status and a single interrupt request. Every pin has its own sense choice (edge or level), its own both-edge override and its own polarity, so one port can mix rising-edge, falling-edge, any-edge, high-level and low-level sources at once. Pin values first pass through a two-stage synchroniser, which makes the block safe against asynchronous pins and means each pin transition is seen exactly once.

Software uses a flat register interface with a write strobe and a combinational read port. It programs four per-pin configuration words (sense, both-edge, polarity, enable mask) and acknowledges edge events through a write-one-to-clear word. It reads back the raw status word and the masked status word. Edge events are sticky until acknowledged. Level conditions are live and cannot be acknowledged. The request output is high while any enabled pin has status.

To change a pin's sense settings without a false request, software must mask the pin, reprogram it, clear its status, and then unmask it.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset every configuration word, the raw status and the masked status read 0, and `irq` is 0.
- R2: With sense=0, both=0 and polarity=1, a rising pin transition sets that pin's raw status. A falling transition does not.
- R3: With sense=0, both=0 and polarity=0, a falling pin transition sets that pin's raw status. A rising transition does not.
- R4: With sense=0 and both=1, either transition sets raw status, and the polarity bit has no effect.
- R5: Edge status stays set until a write to the clear word (address 4) with a 1 in that pin's bit. A 0 bit in that write leaves the pin's status unchanged.
- R6: With sense=1, raw status equals the synchronised pin level when polarity=1, and its inverse when polarity=0. Writes to the clear word do not change it.
- R7: Masked status is raw status AND the mask word. `irq` is the OR of the masked status bits.
- R8: A pin change is visible in level status at the second clock edge after it reaches `pin_in`, and in edge status at the third. A pin that is held steady after its status is cleared sets no new status.
- R9: When an edge is detected in the same cycle as a clear of that pin, the status ends up set.
- R10: If software masks a pin, reconfigures it, clears its status and then unmasks it, `irq` stays 0, even when the pin toggled during the reconfiguration.
- R11: The register addresses are: sense 0, both-edge 1, polarity 2, mask 3, clear 4, raw status 5, masked status 6. Addresses 4 and 7 read 0, and each configuration word reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin values |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | NUM_PINS | Write data, one bit per pin |
| rd_addr | input | 3 | Read address |
| rd_data | output | NUM_PINS | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A detected edge on a pin and a software clear of that same pin can land on one clock edge. The set must win, or an event is lost. The bench provokes this by writing the clear word in the cycle when the synchronised transition is in flight, that is, two negative edges after the pin change. It then expects the raw status bit to read 1 afterwards, and expects a later clear to remove it. The second overlap is a pin that toggles while its settings are being changed, and here the bench judges the request line over several cycles after unmasking.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE = 3'd0,
    REG_BOTH  = 3'd1,
    REG_POL   = 3'd2,
    REG_MASK  = 3'd3,
    REG_CLEAR = 3'd4,
    REG_RAW   = 3'd5,
    REG_MSTAT = 3'd6,
    REG_NONE  = 3'd7
  } reg_addr_e;

  // Edge qualifier: any edge when both is set, otherwise the polarity picks one.
  function automatic logic edge_match(input logic both, input logic pol,
                                      input logic rise, input logic fall);
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level qualifier: active-high when pol is set, active-low otherwise.
  function automatic logic level_match(input logic pol, input logic lvl);
    return pol ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] sense_q,
  output logic [NUM_PINS-1:0] both_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic [NUM_PINS-1:0] clr_pulse
);

  logic hit_sense, hit_both, hit_pol, hit_mask, hit_clear;

  always_comb begin
    hit_sense = wr_en && (wr_addr == REG_SENSE);
    hit_both  = wr_en && (wr_addr == REG_BOTH);
    hit_pol   = wr_en && (wr_addr == REG_POL);
    hit_mask  = wr_en && (wr_addr == REG_MASK);
    hit_clear = wr_en && (wr_addr == REG_CLEAR);
  end

  // The clear word is not stored: it acts as a one-cycle strobe per pin.
  assign clr_pulse = hit_clear ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (hit_sense) sense_q <= wr_data;
      if (hit_both)  both_q  <= wr_data;
      if (hit_pol)   pol_q   <= wr_data;
      if (hit_mask)  mask_q  <= wr_data;
    end
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] synced
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] chain_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= pin_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign synced = chain_q[LAST];

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic synced,
  input  logic sense,
  input  logic both,
  input  logic pol,
  input  logic clr,
  output logic edge_hit,
  output logic stat_q,
  output logic raw
);

  logic prev_q;
  logic rise, fall;

  assign rise     = synced & ~prev_q;
  assign fall     = ~synced & prev_q;
  assign edge_hit = ~sense & edge_match(both, pol, rise, fall);

  // A new edge takes priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= synced;
      if (edge_hit) stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
    end
  end

  assign raw = sense ? level_match(pol, synced) : stat_q;

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [NUM_PINS-1:0] rd_data,
  output logic                irq
);

  logic [NUM_PINS-1:0] sense, both, pol, mask, clr_pulse;
  logic [NUM_PINS-1:0] synced;
  logic [NUM_PINS-1:0] edge_hit, edge_stat, raw, masked;

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sense_q   (sense),
    .both_q    (both),
    .pol_q     (pol),
    .mask_q    (mask),
    .clr_pulse (clr_pulse)
  );

  gpio_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .synced (synced)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .synced   (synced[p]),
      .sense    (sense[p]),
      .both     (both[p]),
      .pol      (pol[p]),
      .clr      (clr_pulse[p]),
      .edge_hit (edge_hit[p]),
      .stat_q   (edge_stat[p]),
      .raw      (raw[p])
    );
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      REG_SENSE: rd_data = sense;
      REG_BOTH:  rd_data = both;
      REG_POL:   rd_data = pol;
      REG_MASK:  rd_data = mask;
      REG_RAW:   rd_data = raw;
      REG_MSTAT: rd_data = masked;
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic [NUM_PINS-1:0] raw,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] sense,
  input logic [NUM_PINS-1:0] pol,
  input logic [NUM_PINS-1:0] synced,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic [NUM_PINS-1:0] edge_stat,
  input logic [NUM_PINS-1:0] clr_pulse
);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((edge_stat & $past(edge_hit)) == $past(edge_hit))); // R9

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_stat) |=> (($past(edge_stat) & ~$past(clr_pulse) & ~edge_stat) == '0)); // R5

  AST_NO_FREE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_stat) |-> ((edge_stat & ~$past(edge_stat) & ~$past(edge_hit)) == '0)); // R8

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw ^ ~(synced ^ pol)) & sense) == '0); // R6

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & mask) != '0)); // R7

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .raw       (raw),
  .mask      (mask),
  .sense     (sense),
  .pol       (pol),
  .synced    (synced),
  .edge_hit  (edge_hit),
  .edge_stat (edge_stat),
  .clr_pulse (clr_pulse)
);

// File: tb/gpio_irq_sense_tb.sv
module gpio_irq_sense_tb;

  localparam int W = 8;
  localparam logic [2:0] A_SENSE = 3'd0, A_BOTH = 3'd1, A_POL = 3'd2, A_MASK = 3'd3,
                         A_CLR = 3'd4, A_RAW = 3'd5, A_MST = 3'd6, A_NONE = 3'd7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] pin_in;
  logic         wr_en;
  logic [2:0]   wr_addr, rd_addr;
  logic [W-1:0] wr_data, rd_data;
  logic         irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  gpio_irq_sense #(.NUM_PINS(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [W-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected single-pin raw status after a transition to level lvl.
  function automatic logic exp_after(input logic s, input logic b, input logic p, input logic lvl);
    if (s) return p ? lvl : ~lvl;
    return b | (p ? lvl : ~lvl);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(2);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), d);
      chk("R1", d, '0);
    end
    chk("R1 irq", {7'd0, irq}, '0);

    // R11 address map and readback
    wreg(A_SENSE, 8'hA5); wreg(A_BOTH, 8'h3C); wreg(A_POL, 8'h0F); wreg(A_MASK, 8'hF0);
    rreg(A_SENSE, d); chk("R11 sense", d, 8'hA5);
    rreg(A_BOTH,  d); chk("R11 both",  d, 8'h3C);
    rreg(A_POL,   d); chk("R11 pol",   d, 8'h0F);
    rreg(A_MASK,  d); chk("R11 mask",  d, 8'hF0);
    rreg(A_CLR,   d); chk("R11 clear reads 0", d, '0);
    rreg(A_NONE,  d); chk("R11 spare reads 0", d, '0);
    wreg(A_SENSE, '0); wreg(A_BOTH, '0); wreg(A_POL, '0); wreg(A_MASK, '0);
    cycles(3); wreg(A_CLR, '1);

    // Sweep every pin through every sense/both/polarity combination
    for (int p = 0; p < W; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic s, b, pl;
        string req;
        logic [W-1:0] bit_p;
        s = c[2]; b = c[1]; pl = c[0];
        bit_p = W'(1) << p;
        req = s ? "R6" : (b ? "R4" : (pl ? "R2" : "R3"));
        pin_in = '0;
        wreg(A_SENSE, s ? bit_p : '0);
        wreg(A_BOTH,  b ? bit_p : '0);
        wreg(A_POL,   pl ? bit_p : '0);
        cycles(5);
        wreg(A_CLR, '1);
        rreg(A_RAW, d); chk(req, d, exp_after(s, b, pl, 1'b0) && s ? bit_p : '0);
        pin_in[p] = 1'b1;
        cycles(4);
        rreg(A_RAW, d); chk(req, d, exp_after(s, b, pl, 1'b1) ? bit_p : '0);
        chk("R7 masked off", {7'd0, irq}, '0);
        wreg(A_MASK, bit_p);
        rreg(A_MST, d); chk("R7 mstat", d, exp_after(s, b, pl, 1'b1) ? bit_p : '0);
        chk("R7 irq", {7'd0, irq}, {7'd0, exp_after(s, b, pl, 1'b1)});
        wreg(A_MASK, '0);
        wreg(A_CLR, ~bit_p);
        rreg(A_RAW, d); chk("R5 zero bit keeps", d, exp_after(s, b, pl, 1'b1) ? bit_p : '0);
        wreg(A_CLR, bit_p);
        rreg(A_RAW, d); chk(s ? "R6 clear ignored" : "R5 clear", d, (s && pl) ? bit_p : '0);
        pin_in[p] = 1'b0;
        cycles(4);
        rreg(A_RAW, d); chk(req, d, exp_after(s, b, pl, 1'b0) ? bit_p : '0);
      end
    end
    wreg(A_SENSE, '0); wreg(A_BOTH, '0); wreg(A_POL, '0);
    cycles(4); wreg(A_CLR, '1);

    // R8 edge latency and single set per transition
    wreg(A_POL, 8'h01);
    pin_in[0] = 1'b1;
    @(negedge clk); rreg(A_RAW, d); chk("R8 edge n1", d, '0);
    @(negedge clk); rreg(A_RAW, d); chk("R8 edge n2", d, '0);
    @(negedge clk); rreg(A_RAW, d); chk("R8 edge n3", d, 8'h01);
    wreg(A_CLR, 8'h01);
    cycles(4); rreg(A_RAW, d); chk("R8 once per transition", d, '0);
    pin_in[0] = 1'b0; cycles(4); wreg(A_CLR, '1);

    // R8 level latency
    wreg(A_SENSE, 8'h02); wreg(A_POL, 8'h02);
    pin_in[1] = 1'b1;
    @(negedge clk); rreg(A_RAW, d); chk("R8 level n1", d, '0);
    @(negedge clk); rreg(A_RAW, d); chk("R8 level n2", d, 8'h02);
    pin_in[1] = 1'b0; wreg(A_SENSE, '0); wreg(A_POL, '0); cycles(4); wreg(A_CLR, '1);

    // R9 edge and clear on the same clock edge
    wreg(A_POL, 8'h01);
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CLR; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    rreg(A_RAW, d); chk("R9 set wins", d, 8'h01);
    wreg(A_CLR, 8'h01);
    rreg(A_RAW, d); chk("R9 later clear", d, '0);
    pin_in[0] = 1'b0; wreg(A_POL, '0); cycles(4); wreg(A_CLR, '1);

    // R10 safe reconfiguration sequence
    wreg(A_POL, 8'h08); wreg(A_MASK, 8'h08);
    cycles(2);
    chk("R10 idle", {7'd0, irq}, '0);
    wreg(A_MASK, '0);
    pin_in[3] = 1'b1;
    cycles(4);
    wreg(A_POL, '0);
    rreg(A_RAW, d); chk("R10 stale status present", d, 8'h08);
    chk("R10 masked during change", {7'd0, irq}, '0);
    wreg(A_CLR, 8'h08);
    wreg(A_MASK, 8'h08);
    for (int k = 0; k < 5; k++) begin
      chk("R10 no spurious irq", {7'd0, irq}, '0);
      @(negedge clk);
    end
    pin_in[3] = 1'b0;
    cycles(4);
    chk("R10 genuine falling edge", {7'd0, irq}, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule